// File: doc/BRIEF.md
# NAND Page Buffer Transfer Sequencer

This block moves one small-page NAND page between a byte stream on the flash side and an 8-Kbyte shared buffer RAM. The RAM is divided into eight 1-Kbyte buffers. A transfer always uses the buffer whose number is the page index modulo eight. Inside each buffer, offsets 0 to 511 hold main data, 512 to 527 hold spare data, and 528 to 1023 are reserved. A start pulse supplies the page index, a main/spare select, a byte count, a column offset and a direction. The sequencer then walks the buffer offsets in ascending order. It exchanges each byte through a valid/ready handshake and reports completion with a one-cycle done pulse and a sticky interrupt flag.

A host port gives software byte access to the same RAM while a transfer runs. Only the low 13 bits of the host address are used, so the 8-Kbyte image repeats across the whole bank address space. The sequencer has priority on the single RAM port. A host access to the buffer under transfer is held off until the transfer ends. Accesses to the other buffers go ahead in any cycle where the sequencer leaves the RAM free.

Top module: `nand_pagebuf_xfer`

## Requirements
- R1: A transfer touches only buffer `page_idx mod 8`, which is RAM address bits [12:10]. Bits [9:0] are the offset inside that buffer.
- R2: When `byte_cnt` is 0, the transfer moves 528 bytes at offsets 0 to 527 in ascending order: the main region first, then the spare region. `spare_sel` and `col_off` have no effect in this case.
- R3: A transfer never reads or writes offsets 528 to 1023 of any buffer.
- R4: When `byte_cnt` is non-zero, the first offset is `col_off`, plus 512 when `spare_sel` is 1. The length is the smaller of `byte_cnt` and `528 - first offset`. The length is 0 when the first offset is 528 or more.
- R5: With `prog` = 0, bytes flow from `fin_*` into the RAM. With `prog` = 1, bytes flow from the RAM out on `fout_*`.
- R6: A byte moves only on a cycle with valid and ready both high. `fout_valid` stays high with stable `fout_data` until `fout_ready` is seen. `fin_ready` and `fout_valid` are never high together.
- R7: A host access uses `h_addr` modulo 8192. Bits above bit 12 have no effect.
- R8: A host access is accepted on a clock edge where `h_req` is 1 and `h_wait` is 0. An accepted write updates the RAM at that edge. An accepted read returns its byte on `h_rdata` in the next cycle, with `h_rvalid` = 1.
- R9: When the sequencer uses the RAM in a cycle, a host request in that cycle sees `h_wait` = 1.
- R10: While `busy` is 1, a host access to the active buffer sees `h_wait` = 1. A host access to any other buffer in a cycle with no sequencer RAM use proceeds with `h_wait` = 0.
- R11: `busy` goes to 1 in the cycle after a start with non-zero length. `done` is 1 for exactly the cycle after the last byte handshake, and `busy` is 0 from that cycle. A zero-length start gives `done` in the next cycle without raising `busy`.
- R12: `irq` is set in the same cycle as `done` when `irq_en` was 1, and it stays set until `irq_clr`. If both happen in the same cycle, setting wins.
- R13: A start pulse while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse for a transfer |
| page_idx | input | 16 | Page index; the low 3 bits pick the buffer |
| spare_sel | input | 1 | 1 starts a counted transfer in the spare region |
| byte_cnt | input | 10 | Byte count; 0 means the whole page |
| col_off | input | 10 | Column offset inside the selected region |
| prog | input | 1 | Direction: 1 = RAM to flash, 0 = flash to RAM |
| irq_en | input | 1 | Enables setting of the interrupt flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky completion interrupt flag |
| fin_valid | input | 1 | Flash-to-RAM byte valid |
| fin_ready | output | 1 | Sequencer accepts a flash byte |
| fin_data | input | 8 | Flash-to-RAM byte |
| fout_valid | output | 1 | RAM-to-flash byte valid |
| fout_ready | input | 1 | Flash side accepts the byte |
| fout_data | output | 8 | RAM-to-flash byte |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 16 | Host bank address (folded modulo 8192) |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte |
| h_wait | output | 1 | Host access held off this cycle |
| h_rvalid | output | 1 | `h_rdata` holds the read result |

## Verification
The assertions check the stream rules, the host arbitration and the completion flags on every cycle. These cover the held `fout_valid` with stable data, exclusive stream directions, host wait on sequencer use or an active-buffer hit, read return timing, `done` outside `busy`, and interrupt stickiness. They also check that every sequencer RAM access stays below offset 528 inside the active buffer.

Only the bench scenarios can show that the right bytes land at the right offsets. The bench covers whole-page ordering, region start and clamping to the page end, and untouched neighbours and reserved bytes. It also covers host address folding and that a start during a transfer changes nothing.

// File: rtl/nand_pagebuf_pkg.sv
// Package nand_pagebuf_pkg
// Shared geometry constants and state type for the page buffer sequencer.
// Assumes a small-page layout: eight 1-Kbyte buffers of main + spare + reserved.
package nand_pagebuf_pkg;
    localparam int BUF_CNT     = 8;
    localparam int BUF_BYTES   = 1024;
    localparam int MAIN_BYTES  = 512;
    localparam int SPARE_BYTES = 16;
    localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
    localparam int BYTE_W      = 8;
    localparam int BUF_W       = $clog2(BUF_CNT);
    localparam int OFF_W       = $clog2(BUF_BYTES);
    localparam int RAM_AW      = BUF_W + OFF_W;
    localparam int LEN_W       = OFF_W + 1;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_RECV  = 3'd1,
        SQ_FETCH = 3'd2,
        SQ_LATCH = 3'd3,
        SQ_SEND  = 3'd4
    } sq_state_t;
endpackage

// File: rtl/nbuf_ram.sv
// Module nbuf_ram
// Single-port byte-addressed buffer RAM with a registered read port.
// Stored as 32-bit words with byte-lane writes to keep the array short.
// Assumes at most one access (read or write) per cycle.
module nbuf_ram
    import nand_pagebuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [RAM_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int LANE_W = 2;
    localparam int WORDS  = (1 << RAM_AW) >> LANE_W;
    localparam int WORD_W = BYTE_W << LANE_W;

    logic [WORD_W-1:0] mem [WORDS];
    logic [LANE_W+2:0] lane_lsb;

    // Bit position of the addressed byte lane inside a word.
    always_comb lane_lsb = {addr[LANE_W-1:0], 3'b000};

    // Byte-lane write into the word array.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr[RAM_AW-1:LANE_W]][lane_lsb +: BYTE_W] <= wdata;
        end
    end

    // Registered read of the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= mem[addr[RAM_AW-1:LANE_W]][lane_lsb +: BYTE_W];
        end
    end
endmodule

// File: rtl/nbuf_seq.sv
// Module nbuf_seq
// Transfer sequencer: works out start offset and length from the start
// request, walks buffer offsets upward and moves bytes over the stream
// handshakes. It raises done and the sticky interrupt at the end.
// Assumes the RAM grants it every cycle it asserts seq_en.
module nbuf_seq
    import nand_pagebuf_pkg::*;
#(
    parameter int PIDX_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PIDX_W-1:0] page_idx,
    input  logic              spare_sel,
    input  logic [OFF_W-1:0]  byte_cnt,
    input  logic [OFF_W-1:0]  col_off,
    input  logic              prog,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic [BUF_W-1:0]  act_buf,
    output logic              seq_en,
    output logic              seq_we,
    output logic [RAM_AW-1:0] seq_addr,
    output logic [BYTE_W-1:0] seq_wdata,
    input  logic [BYTE_W-1:0] ram_rdata,
    input  logic              fin_valid,
    output logic              fin_ready,
    input  logic [BYTE_W-1:0] fin_data,
    output logic              fout_valid,
    input  logic              fout_ready,
    output logic [BYTE_W-1:0] fout_data
);
    sq_state_t         state;
    logic [OFF_W-1:0]  off_q;
    logic [LEN_W-1:0]  left_q;
    logic [BYTE_W-1:0] hold_q;
    logic [LEN_W-1:0]  first_off, room, req_len;
    logic              last_hs, fin_evt, go;
    logic              unused_page;

    assign unused_page = ^page_idx[PIDX_W-1:BUF_W];

    // Start offset and clamped length of the requested transfer.
    always_comb begin
        room = '0;
        if (byte_cnt == '0) begin
            first_off = '0;
            req_len   = LEN_W'(PAGE_BYTES);
        end else begin
            first_off = (spare_sel ? LEN_W'(MAIN_BYTES) : '0) + {1'b0, col_off};
            if (first_off < LEN_W'(PAGE_BYTES)) begin
                room = LEN_W'(PAGE_BYTES) - first_off;
            end
            req_len = ({1'b0, byte_cnt} < room) ? {1'b0, byte_cnt} : room;
        end
    end

    // Handshake and completion events.
    always_comb begin
        go      = (state == SQ_IDLE) && start;
        last_hs = (left_q == LEN_W'(1)) &&
                  (((state == SQ_RECV) && fin_valid) ||
                   ((state == SQ_SEND) && fout_ready));
        fin_evt = last_hs || (go && (req_len == '0));
    end

    // Transfer state machine and offset walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            off_q   <= '0;
            left_q  <= '0;
            hold_q  <= '0;
            act_buf <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (go && (req_len != '0)) begin
                        act_buf <= page_idx[BUF_W-1:0];
                        off_q   <= first_off[OFF_W-1:0];
                        left_q  <= req_len;
                        state   <= prog ? SQ_FETCH : SQ_RECV;
                    end
                end
                SQ_RECV: begin
                    if (fin_valid) begin
                        off_q  <= off_q + OFF_W'(1);
                        left_q <= left_q - LEN_W'(1);
                        if (left_q == LEN_W'(1)) state <= SQ_IDLE;
                    end
                end
                SQ_FETCH: state <= SQ_LATCH;
                SQ_LATCH: begin
                    hold_q <= ram_rdata;
                    state  <= SQ_SEND;
                end
                SQ_SEND: begin
                    if (fout_ready) begin
                        off_q  <= off_q + OFF_W'(1);
                        left_q <= left_q - LEN_W'(1);
                        state  <= (left_q == LEN_W'(1)) ? SQ_IDLE : SQ_FETCH;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Done pulse and sticky interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            irq  <= 1'b0;
        end else begin
            done <= fin_evt;
            if (fin_evt && irq_en) irq <= 1'b1;
            else if (irq_clr)      irq <= 1'b0;
        end
    end

    // Stream and RAM-side outputs decoded from the state.
    always_comb begin
        busy       = (state != SQ_IDLE);
        fin_ready  = (state == SQ_RECV);
        fout_valid = (state == SQ_SEND);
        fout_data  = hold_q;
        seq_en     = ((state == SQ_RECV) && fin_valid) || (state == SQ_FETCH);
        seq_we     = (state == SQ_RECV);
        seq_addr   = {act_buf, off_q};
        seq_wdata  = fin_data;
    end
endmodule

// File: rtl/nbuf_host.sv
// Module nbuf_host
// Host port arbitration: folds the bank address onto the RAM, holds the
// host off when the sequencer uses the RAM or the active buffer is hit,
// and flags returned read data.
// Assumes the host keeps its request stable while h_wait is high.
module nbuf_host
    import nand_pagebuf_pkg::*;
#(
    parameter int HOST_AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_req,
    input  logic               h_we,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic               seq_en,
    input  logic               busy,
    input  logic [BUF_W-1:0]   act_buf,
    output logic               h_wait,
    output logic               host_go,
    output logic [RAM_AW-1:0]  host_addr,
    output logic               h_rvalid
);
    logic hits_active;
    logic unused_hi;

    assign unused_hi = ^h_addr[HOST_AW-1:RAM_AW];

    // Address fold and wait decision.
    always_comb begin
        host_addr   = h_addr[RAM_AW-1:0];
        hits_active = busy && (host_addr[RAM_AW-1:OFF_W] == act_buf);
        h_wait      = h_req && (seq_en || hits_active);
        host_go     = h_req && !h_wait;
    end

    // Read-return flag for the cycle after an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) h_rvalid <= 1'b0;
        else        h_rvalid <= host_go && !h_we;
    end
endmodule

// File: rtl/nand_pagebuf_xfer.sv
// Module nand_pagebuf_xfer
// Top of the page buffer transfer sequencer: connects the sequencer, the
// host arbiter and the shared single-port RAM, with the sequencer first
// on the RAM port.
// Assumes the flash-side stream and the host share one clock.
module nand_pagebuf_xfer
    import nand_pagebuf_pkg::*;
#(
    parameter int PIDX_W  = 16,
    parameter int HOST_AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PIDX_W-1:0]  page_idx,
    input  logic               spare_sel,
    input  logic [OFF_W-1:0]   byte_cnt,
    input  logic [OFF_W-1:0]   col_off,
    input  logic               prog,
    input  logic               irq_en,
    input  logic               irq_clr,
    output logic               busy,
    output logic               done,
    output logic               irq,
    input  logic               fin_valid,
    output logic               fin_ready,
    input  logic [BYTE_W-1:0]  fin_data,
    output logic               fout_valid,
    input  logic               fout_ready,
    output logic [BYTE_W-1:0]  fout_data,
    input  logic               h_req,
    input  logic               h_we,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic [BYTE_W-1:0]  h_wdata,
    output logic [BYTE_W-1:0]  h_rdata,
    output logic               h_wait,
    output logic               h_rvalid
);
    logic              seq_en, seq_we, host_go;
    logic [RAM_AW-1:0] seq_addr, host_addr, ram_addr;
    logic [BYTE_W-1:0] seq_wdata, ram_wdata, ram_rdata;
    logic [BUF_W-1:0]  act_buf;
    logic              ram_en, ram_we;

    nbuf_seq #(.PIDX_W(PIDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .page_idx(page_idx),
        .spare_sel(spare_sel), .byte_cnt(byte_cnt), .col_off(col_off),
        .prog(prog), .irq_en(irq_en), .irq_clr(irq_clr),
        .busy(busy), .done(done), .irq(irq), .act_buf(act_buf),
        .seq_en(seq_en), .seq_we(seq_we), .seq_addr(seq_addr),
        .seq_wdata(seq_wdata), .ram_rdata(ram_rdata),
        .fin_valid(fin_valid), .fin_ready(fin_ready), .fin_data(fin_data),
        .fout_valid(fout_valid), .fout_ready(fout_ready), .fout_data(fout_data)
    );

    nbuf_host #(.HOST_AW(HOST_AW)) u_host (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
        .seq_en(seq_en), .busy(busy), .act_buf(act_buf),
        .h_wait(h_wait), .host_go(host_go), .host_addr(host_addr),
        .h_rvalid(h_rvalid)
    );

    // RAM port mux with the sequencer taking precedence.
    always_comb begin
        ram_en    = seq_en || host_go;
        ram_we    = seq_en ? seq_we    : h_we;
        ram_addr  = seq_en ? seq_addr  : host_addr;
        ram_wdata = seq_en ? seq_wdata : h_wdata;
    end

    nbuf_ram u_ram (
        .clk(clk), .rst_n(rst_n), .en(ram_en), .we(ram_we),
        .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
    );

    assign h_rdata = ram_rdata;
endmodule

// File: rtl/nand_pagebuf_xfer_chk.sv
// Module nand_pagebuf_xfer_chk
// Cycle-by-cycle protocol checks for the page buffer sequencer, bound to
// the top module. Assumes the package geometry.
module nand_pagebuf_xfer_chk
    import nand_pagebuf_pkg::*;
#(
    parameter int HOST_AW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               irq,
    input logic               irq_clr,
    input logic               fin_ready,
    input logic               fout_valid,
    input logic               fout_ready,
    input logic [BYTE_W-1:0]  fout_data,
    input logic               h_req,
    input logic               h_we,
    input logic               h_wait,
    input logic               h_rvalid,
    input logic [HOST_AW-1:0] h_addr,
    input logic               seq_en,
    input logic [RAM_AW-1:0]  seq_addr,
    input logic [BUF_W-1:0]   act_buf
);
    // R6
    fout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fout_valid && !fout_ready |=> fout_valid && $stable(fout_data));

    // R6
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fin_ready && fout_valid));

    // R3
    no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_en |-> (seq_addr[OFF_W-1:0] < OFF_W'(PAGE_BYTES)));

    // R1
    own_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_en |-> (seq_addr[RAM_AW-1:OFF_W] == act_buf) && busy);

    // R9
    seq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && seq_en |-> h_wait);

    // R10
    active_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && busy && (h_addr[RAM_AW-1:OFF_W] == act_buf) |-> h_wait);

    // R8
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && !h_wait && !h_we |=> h_rvalid);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq);
endmodule

bind nand_pagebuf_xfer nand_pagebuf_xfer_chk #(.HOST_AW(HOST_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .irq(irq),
    .irq_clr(irq_clr), .fin_ready(fin_ready), .fout_valid(fout_valid),
    .fout_ready(fout_ready), .fout_data(fout_data), .h_req(h_req),
    .h_we(h_we), .h_wait(h_wait), .h_rvalid(h_rvalid), .h_addr(h_addr),
    .seq_en(seq_en), .seq_addr(seq_addr), .act_buf(act_buf)
);

// File: tb/nand_pagebuf_xfer_bench.sv
`timescale 1ns/1ps
// Bench for nand_pagebuf_xfer: a vector table of flash-to-RAM transfers
// followed by directed tests for reset, programming, host folding,
// arbitration, interrupts and ignored starts.
module nand_pagebuf_xfer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, spare_sel = 1'b0, prog = 1'b0;
    logic [15:0] page_idx = '0;
    logic [9:0]  byte_cnt = '0, col_off = '0;
    logic        irq_en = 1'b0, irq_clr = 1'b0;
    logic        busy, done, irq;
    logic        fin_valid = 1'b0, fin_ready;
    logic [7:0]  fin_data = '0;
    logic        fout_valid, fout_ready = 1'b0;
    logic [7:0]  fout_data;
    logic        h_req = 1'b0, h_we = 1'b0;
    logic [15:0] h_addr = '0;
    logic [7:0]  h_wdata = '0, h_rdata;
    logic        h_wait, h_rvalid;

    int total = 0;
    int bad   = 0;
    logic last_rv;

    always #2 clk = ~clk;

    nand_pagebuf_xfer u_nand_pagebuf_xfer (
        .clk(clk), .rst_n(rst_n), .start(start), .page_idx(page_idx),
        .spare_sel(spare_sel), .byte_cnt(byte_cnt), .col_off(col_off),
        .prog(prog), .irq_en(irq_en), .irq_clr(irq_clr),
        .busy(busy), .done(done), .irq(irq),
        .fin_valid(fin_valid), .fin_ready(fin_ready), .fin_data(fin_data),
        .fout_valid(fout_valid), .fout_ready(fout_ready), .fout_data(fout_data),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_wait(h_wait), .h_rvalid(h_rvalid)
    );

    // Columns: page, spare_sel, byte_cnt, col_off, expected start, expected length.
    localparam int NV = 7;
    localparam int VEC [NV][6] = '{
        '{9,  0, 0,   5,   0,   528},
        '{20, 1, 0,   0,   0,   528},
        '{3,  0, 100, 50,  50,  100},
        '{14, 1, 8,   4,   516, 8},
        '{7,  1, 40,  0,   512, 16},
        '{0,  0, 600, 500, 500, 28},
        '{15, 1, 5,   20,  532, 0}
    };

    function automatic logic [7:0] pat(int v, int i);
        return 8'((i * 13) + (v * 31) + 7);
    endfunction

    function automatic logic [15:0] mk(int hi, int b, int off);
        return {3'(hi), 3'(b), 10'(off)};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic host_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
        #1;
        while (h_wait) begin @(negedge clk); #1; end
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
    endtask

    task automatic host_rd(logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b0; h_addr = a;
        #1;
        while (h_wait) begin @(negedge clk); #1; end
        @(negedge clk);
        h_req = 1'b0;
        d = h_rdata;
        last_rv = h_rvalid;
    endtask

    task automatic start_xfer(int pg, int sel, int cnt, int col, bit dir);
        @(negedge clk);
        start = 1'b1; page_idx = 16'(pg); spare_sel = sel[0];
        byte_cnt = 10'(cnt); col_off = 10'(col); prog = dir;
        @(negedge clk);
        start = 1'b0;
        #1;
    endtask

    // Feeds n bytes with an idle cycle before every fifth byte; returns just after the last edge.
    task automatic feed(int n, int v);
        for (int i = 0; i < n; i++) begin
            if (i % 5 == 3) begin
                @(negedge clk);
                fin_valid = 1'b0;
            end
            @(negedge clk);
            fin_valid = 1'b1; fin_data = pat(v, i);
            #1;
            while (!fin_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        fin_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] d;
        int errs, first_bad_i, first_bad_v;

        repeat (3) @(negedge clk);
        #1;
        // Reset state: all status outputs low.
        chk(!busy && !done && !irq && !fin_ready && !fout_valid && !h_rvalid,
            "R11 reset state", {busy, done, irq, fin_ready, fout_valid, h_rvalid}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table: flash-to-RAM transfers with placement and boundary checks.
        for (int v = 0; v < NV; v++) begin
            int pg, st, ln, b;
            pg = VEC[v][0]; st = VEC[v][4]; ln = VEC[v][5]; b = pg % 8;
            if (st > 0) host_wr(mk(v, b, st - 1), 8'hA5);
            host_wr(mk(v + 1, b, st + ln), 8'h5A);
            host_wr(mk(v + 2, b, 600), 8'h3C);
            start_xfer(pg, VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
            if (ln == 0) begin
                chk(done && !busy, "R4 R11 zero-length done", {done, busy}, 2);
            end else begin
                chk(busy, "R11 busy after start", busy, 1);
                feed(ln, v);
                chk(done && !busy, "R11 done after last byte", {done, busy}, 2);
                @(negedge clk);
                #1;
                chk(!done, "R11 done single cycle", done, 0);
            end
            errs = 0; first_bad_i = 0; first_bad_v = 0;
            for (int i = 0; i < ln; i++) begin
                host_rd(mk(v + 3, b, st + i), d);
                if (d !== pat(v, i)) begin
                    if (errs == 0) begin first_bad_i = i; first_bad_v = d; end
                    errs++;
                end
            end
            chk(errs == 0, $sformatf("R1 R2 R4 R5 data vec%0d at byte %0d", v, first_bad_i),
                first_bad_v, pat(v, first_bad_i));
            if (st > 0) begin
                host_rd(mk(v, b, st - 1), d);
                chk(d == 8'hA5, $sformatf("R4 byte before start vec%0d", v), d, 8'hA5);
            end
            host_rd(mk(v, b, st + ln), d);
            chk(d == 8'h5A, $sformatf("R4 byte after end vec%0d", v), d, 8'h5A);
            host_rd(mk(v, b, 600), d);
            chk(d == 8'h3C, $sformatf("R3 reserved byte vec%0d", v), d, 8'h3C);
        end
        chk(!irq, "R12 no irq while disabled", irq, 0);

        // R7: host address folding modulo 8192.
        host_wr(16'hE123, 8'h5B);
        host_rd(16'h0123, d);
        chk(d == 8'h5B, "R7 folded address alias", d, 8'h5B);
        chk(last_rv, "R8 read valid flag", last_rv, 1);
        host_rd(16'h6123, d);
        chk(d == 8'h5B, "R7 second alias", d, 8'h5B);

        // R5/R6: programming direction out of buffer 2 spare bytes 512..519.
        for (int i = 0; i < 8; i++) host_wr(mk(0, 2, 512 + i), 8'(8'h40 + i));
        begin
            logic [7:0] rec [8];
            int got, k, stall_bad;
            bit stalled, fin_seen;
            logic [7:0] stall_d;
            got = 0; k = 0; stall_bad = 0; stalled = 0; fin_seen = 0; stall_d = '0;
            start_xfer(10, 1, 8, 0, 1'b1);
            while (got < 8 && k < 400) begin
                @(negedge clk);
                fout_ready = k[0] & k[1];
                k++;
                #1;
                if (fin_ready) fin_seen = 1;
                if (stalled && (!fout_valid || fout_data != stall_d)) stall_bad++;
                stalled = fout_valid && !fout_ready;
                stall_d = fout_data;
                if (fout_valid && fout_ready) begin
                    rec[got] = fout_data;
                    got++;
                end
            end
            @(negedge clk);
            fout_ready = 1'b0;
            #1;
            chk(done && !busy, "R11 program done", {done, busy}, 2);
            chk(stall_bad == 0, "R6 output held while not ready", stall_bad, 0);
            chk(!fin_seen, "R6 flash input not ready while programming", fin_seen, 0);
            errs = 0;
            for (int i = 0; i < 8; i++) if (rec[i] !== 8'(8'h40 + i)) errs++;
            chk(errs == 0, "R5 program stream bytes", errs, 0);
        end
        prog = 1'b0;

        // R9/R10: host arbitration during a transfer into buffer 5.
        start_xfer(5, 0, 4, 0, 1'b0);
        @(negedge clk);
        fin_valid = 1'b1; fin_data = pat(20, 0);
        h_req = 1'b1; h_we = 1'b1; h_addr = 16'h0C10; h_wdata = 8'h77;
        #1;
        chk(h_wait, "R9 host waits on sequencer use", h_wait, 1);
        @(negedge clk);
        fin_valid = 1'b0;
        #1;
        chk(!h_wait, "R10 other buffer proceeds", h_wait, 0);
        @(negedge clk);
        h_addr = 16'h1464; h_wdata = 8'h99;
        #1;
        chk(h_wait, "R10 active buffer held", h_wait, 1);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            fin_valid = 1'b1; fin_data = pat(20, i);
        end
        @(negedge clk);
        fin_valid = 1'b0;
        #1;
        chk(done && !h_wait, "R10 active buffer released at end", {done, h_wait}, 2);
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
        host_rd(16'h0C10, d);
        chk(d == 8'h77, "R10 other buffer write landed", d, 8'h77);
        host_rd(16'h1464, d);
        chk(d == 8'h99, "R10 held write landed", d, 8'h99);
        errs = 0;
        for (int i = 0; i < 4; i++) begin
            host_rd(mk(0, 5, i), d);
            if (d !== pat(20, i)) errs++;
        end
        chk(errs == 0, "R9 transfer bytes under contention", errs, 0);

        // R12/R13: interrupt and start while busy.
        irq_en = 1'b1;
        start_xfer(6, 0, 2, 10, 1'b0);
        start_xfer(1, 0, 0, 0, 1'b0);
        chk(busy, "R13 still busy after ignored start", busy, 1);
        feed(2, 30);
        chk(done && !busy, "R13 ends after original count", {done, busy}, 2);
        chk(irq, "R12 irq with done", irq, 1);
        irq_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(irq, "R12 irq sticky", irq, 1);
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        #1;
        chk(!irq, "R12 irq cleared", irq, 0);
        host_rd(mk(0, 6, 11), d);
        chk(d == pat(30, 1), "R13 original transfer data", d, pat(30, 1));
        host_rd(mk(0, 1, 0), d);
        chk(d == pat(0, 0), "R13 ignored start touched nothing", d, pat(0, 0));

        summary();
    end
endmodule